// File: doc/BRIEF.md
# Joypad Matrix Input Register

The block is a single memory-mapped register that reads eight push-button levels through a two-group scan matrix. Software writes two active-low select bits. One of them enables the action group (Start, Select, B, A) and the other enables the direction group (Down, Up, Left, Right). A read returns the select bits and a 4-bit active-low nibble in which a pressed button of any enabled group shows as a zero. When both groups are enabled, their presses combine into the same nibble.

Two states cannot happen with a rocking direction pad: Up together with Down, and Left together with Right. The block removes these pairs unless a bypass input is set, so the game sees only valid direction combinations. When neither group is selected, the nibble carries a multiplayer identification bit in place of button data. Every time the nibble leaves the all-released value 0xF, the block raises a single-cycle interrupt request.

Top module: `joypad_matrix_reg`

## Requirements
- R1: After reset, both select bits read as 1 and `rd_data` equals 0xFF minus `multi_req` (0xFF when `multi_req` is 0, 0xFE when it is 1).
- R2: A cycle with `wr_en` high latches `wr_data[5]` as the action select and `wr_data[4]` as the direction select. These appear at `rd_data[5]` and `rd_data[4]` from the next cycle on. All other write bits are ignored, and `rd_data[7:6]` always read 1.
- R3: With only the action group selected (bit 5 = 0, bit 4 = 1), `rd_data[3:0]` is 0xF with a bit cleared for each pressed action button. The mapping is Start→3, Select→2, B→1, A→0, taken from `btn_raw[3:0]`. The direction buttons have no effect.
- R4: With only the direction group selected (bit 5 = 1, bit 4 = 0), pressed directions clear their bits. The mapping is Down→3, Up→2, Left→1, Right→0, taken from `btn_raw[7:4]`. The action buttons have no effect.
- R5: When `dir_bypass` is 0, a pressed Up masks a pressed Down, and a pressed Left masks a pressed Right, before the groups are merged.
- R6: When `dir_bypass` is 1, opposing directions are reported exactly as pressed.
- R7: With both groups selected (bits 5 and 4 both 0), the nibble is 0xF with the bits of both groups' pressed buttons cleared.
- R8: With neither group selected, `rd_data[3:0]` equals 0xF minus `multi_req`, whatever the buttons are doing.
- R9: When the nibble changes from 0xF to any other value, `irq` is high for exactly one cycle, in the cycle after the change.
- R10: While the nibble stays away from 0xF, `irq` stays low. Once the nibble has returned to 0xF, a new departure raises `irq` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bits 5 and 4 are the select bits |
| btn_raw | input | 8 | Button levels, active high; [3:0] action group, [7:4] direction group |
| dir_bypass | input | 1 | Allows opposing directions to be reported together |
| multi_req | input | 1 | Multiplayer identification bit |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that `btn_raw`, `dir_bypass` and `multi_req` are stable and known around each clock edge. They also assume that reset is held for at least one edge before the first checked cycle, because the edge detector relies on the previous sample. The stimulus changes every input only on the falling clock edge and keeps `rst_n` low for several cycles at start-up. The interrupt checks then count cycles from a known released state, with the nibble held at 0xF for at least two edges, so each expected pulse falls in a known cycle.

// File: rtl/joy_pkg.sv
package joy_pkg;

    typedef struct packed {
        logic sel_act;
        logic sel_dir;
    } joy_sel_t;

    typedef struct packed {
        logic idle;
        logic pulse;
    } joy_irq_t;

endpackage

// File: rtl/joy_sel_latch.sv
module joy_sel_latch #(
    parameter int DATA_W  = 8,
    parameter int ACT_BIT = 5,
    parameter int DIR_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sel_act,
    output logic              sel_dir
);
    import joy_pkg::*;

    joy_sel_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.sel_act = wr_data[ACT_BIT];
            st_d.sel_dir = wr_data[DIR_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sel_act: 1'b1, sel_dir: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_act = st_q.sel_act;
    assign sel_dir = st_q.sel_dir;

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sel_act == $past(wr_data[ACT_BIT]) && sel_dir == $past(wr_data[DIR_BIT])))
        else $error("select bits not loaded"); // R2

    AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable({sel_act, sel_dir}))
        else $error("select bits changed without a write"); // R2

endmodule

// File: rtl/joy_dir_filter.sv
module joy_dir_filter #(
    parameter int GRP_W = 4
) (
    input  logic [GRP_W-1:0] dir_raw,
    input  logic             bypass,
    output logic [GRP_W-1:0] dir_clean
);
    localparam int POS_DOWN  = 3;
    localparam int POS_UP    = 2;
    localparam int POS_LEFT  = 1;
    localparam int POS_RIGHT = 0;

    always_comb begin
        dir_clean = dir_raw;
        if (!bypass) begin
            if (dir_raw[POS_UP])   dir_clean[POS_DOWN]  = 1'b0;
            if (dir_raw[POS_LEFT]) dir_clean[POS_RIGHT] = 1'b0;
        end
    end

    always_comb begin
        if (!bypass) begin
            AST_NO_OPPOSE: assert (!(dir_clean[POS_DOWN] && dir_clean[POS_UP]) &&
                                   !(dir_clean[POS_LEFT] && dir_clean[POS_RIGHT]))
                else $error("opposing directions escaped"); // R5
        end else begin
            AST_BYPASS_RAW: assert (dir_clean == dir_raw)
                else $error("bypass altered directions"); // R6
        end
    end

endmodule

// File: rtl/joy_nibble_merge.sv
module joy_nibble_merge #(
    parameter int GRP_W = 4
) (
    input  logic             sel_act,
    input  logic             sel_dir,
    input  logic [GRP_W-1:0] act_btn,
    input  logic [GRP_W-1:0] dir_btn,
    input  logic             multi_req,
    output logic [GRP_W-1:0] nibble
);
    localparam logic [GRP_W-1:0] NIB_FULL = {GRP_W{1'b1}};

    always_comb begin
        nibble = NIB_FULL;
        if (sel_act && sel_dir) begin
            nibble = NIB_FULL - GRP_W'(multi_req);
        end else begin
            if (!sel_act) nibble = nibble & ~act_btn;
            if (!sel_dir) nibble = nibble & ~dir_btn;
        end
    end

    always_comb begin
        if (sel_act && sel_dir) begin
            AST_IDLE_ID: assert (nibble[GRP_W-1:1] == NIB_FULL[GRP_W-1:1] && nibble[0] == !multi_req)
                else $error("idle nibble wrong"); // R8
        end
        if (!sel_act && sel_dir) begin
            AST_ACT_ONLY: assert ((nibble & act_btn) == '0)
                else $error("pressed action bit not cleared"); // R3
        end
    end

endmodule

// File: rtl/joy_irq_edge.sv
module joy_irq_edge #(
    parameter int GRP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] nibble,
    output logic             irq
);
    import joy_pkg::*;

    localparam logic [GRP_W-1:0] NIB_FULL = {GRP_W{1'b1}};

    joy_irq_t st_d, st_q;
    logic     active;

    assign active = (nibble != NIB_FULL);

    always_comb begin
        st_d       = st_q;
        st_d.idle  = !active;
        st_d.pulse = st_q.idle && active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{idle: 1'b1, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.pulse;

    AST_IRQ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq) else $error("irq longer than one cycle"); // R9

    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(nibble) != NIB_FULL)) else $error("irq without active nibble"); // R9

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && active && $past(nibble) != NIB_FULL) |=> !irq)
        else $error("irq repeated while held"); // R10

endmodule

// File: rtl/joypad_matrix_reg.sv
module joypad_matrix_reg #(
    parameter int GRP_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [2*GRP_W-1:0]   btn_raw,
    input  logic                 dir_bypass,
    input  logic                 multi_req,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 irq
);
    localparam int PAD_W   = DATA_W - GRP_W - 2;
    localparam int DIR_BIT = GRP_W;
    localparam int ACT_BIT = GRP_W + 1;

    logic             sel_act, sel_dir;
    logic [GRP_W-1:0] dir_clean;
    logic [GRP_W-1:0] nibble;

    joy_sel_latch #(.DATA_W(DATA_W), .ACT_BIT(ACT_BIT), .DIR_BIT(DIR_BIT)) u_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .sel_act(sel_act), .sel_dir(sel_dir)
    );

    joy_dir_filter #(.GRP_W(GRP_W)) u_filt (
        .dir_raw(btn_raw[2*GRP_W-1:GRP_W]), .bypass(dir_bypass), .dir_clean(dir_clean)
    );

    joy_nibble_merge #(.GRP_W(GRP_W)) u_merge (
        .sel_act(sel_act), .sel_dir(sel_dir),
        .act_btn(btn_raw[GRP_W-1:0]), .dir_btn(dir_clean),
        .multi_req(multi_req), .nibble(nibble)
    );

    joy_irq_edge #(.GRP_W(GRP_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .nibble(nibble), .irq(irq)
    );

    assign rd_data = {{PAD_W{1'b1}}, sel_act, sel_dir, nibble};

    AST_RD_TRACKS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[ACT_BIT:DIR_BIT] == $past(wr_data[ACT_BIT:DIR_BIT])))
        else $error("read does not reflect written select"); // R2

endmodule

// File: tb/joypad_matrix_reg_test.sv
module joypad_matrix_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] btn_raw = 8'h00;
    logic       dir_bypass = 1'b0;
    logic       multi_req = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    joypad_matrix_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .btn_raw(btn_raw), .dir_bypass(dir_bypass), .multi_req(multi_req),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = ~v;
    endtask

    // arithmetic reference: 15 minus the weight of the visible pressed bits
    function automatic int model_nib(input int sel, input int btn, input int bp, input int mp);
        int act_p = btn % 16;
        int dir_p = btn / 16;
        int seen  = 0;
        if (bp == 0) begin
            if ((dir_p / 4) % 2 == 1) dir_p = dir_p % 8;          // Up masks Down
            if ((dir_p / 2) % 2 == 1) dir_p = dir_p - (dir_p % 2); // Left masks Right
        end
        if (sel == 3) return 15 - mp;
        if ((sel / 2) == 0) seen = seen | act_p;
        if ((sel % 2) == 0) seen = seen | dir_p;
        return 15 - seen;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset read", rd_data, 8'hFF);
        multi_req = 1'b1;
        #2 chk("R1 reset read multi", rd_data, 8'hFE);
        multi_req = 1'b0;

        // sweep all selects, buttons, bypass and multiplayer bit
        for (int sel = 0; sel < 4; sel++) begin
            write_reg(8'((sel << 4) | 8'h4A));   // junk in the other bits
            chk("R2 select bits", rd_data[5:4], sel);
            chk("R2 top bits", rd_data[7:6], 3);
            for (int b = 0; b < 256; b++) begin
                for (int bp = 0; bp < 2; bp++) begin
                    for (int mp = 0; mp < 2; mp++) begin
                        @(negedge clk);
                        btn_raw    = 8'(b);
                        dir_bypass = 1'(bp);
                        multi_req  = 1'(mp);
                        #2;
                        case (sel)
                            0: chk("R7 merged", rd_data, 8'hC0 | model_nib(sel, b, bp, mp));
                            1: chk("R3 action", rd_data, 8'hD0 | model_nib(sel, b, bp, mp));
                            2: chk(bp ? "R6 bypass dir" : "R4 R5 dir", rd_data,
                                   8'hE0 | model_nib(sel, b, bp, mp));
                            default: chk("R8 none", rd_data, 8'hF0 | model_nib(sel, b, bp, mp));
                        endcase
                    end
                end
            end
        end
        // directed suppression corners
        write_reg(8'h20);
        @(negedge clk); btn_raw = 8'hC0; dir_bypass = 1'b0; multi_req = 1'b0;
        #2 chk("R5 up masks down", rd_data[3:0], 4'hB);
        dir_bypass = 1'b1;
        #2 chk("R6 up and down", rd_data[3:0], 4'h3);

        // interrupt behaviour
        @(negedge clk); btn_raw = 8'h00; dir_bypass = 1'b0;
        write_reg(8'h10);                 // action only
        repeat (2) @(negedge clk);
        chk("R9 idle no irq", irq, 0);
        btn_raw = 8'h01;                  // press A
        @(negedge clk); chk("R9 irq pulse", irq, 1);
        @(negedge clk); chk("R9 irq one cycle", irq, 0);
        btn_raw = 8'h03;                  // add B, still active
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); chk("R10 no repeat", irq, 0);
        end
        btn_raw = 8'h00;
        @(negedge clk); chk("R10 release quiet", irq, 0);
        btn_raw = 8'h08;                  // Start
        @(negedge clk); chk("R10 re-armed", irq, 1);
        @(negedge clk); chk("R10 re-armed one cycle", irq, 0);
        btn_raw = 8'h00;
        write_reg(8'h20);                 // directions only
        repeat (2) @(negedge clk);
        btn_raw = 8'h0F;                  // action buttons unseen
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); chk("R4 unselected no irq", irq, 0);
        end
        btn_raw = 8'h00;
        write_reg(8'h30);
        repeat (2) @(negedge clk);
        multi_req = 1'b1;
        @(negedge clk); chk("R8 multi irq", irq, 1);
        @(negedge clk); chk("R8 multi irq end", irq, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule